// File: doc/BRIEF.md
# Boot-Block Flash Command Controller

This block sits between a host bus and the cell array of a boot-block style flash device. Bus writes are decoded into commands. Program and erase each take two writes: a setup write, then a write carrying the target. After the second write the block runs the operation on its own. It drives a request/acknowledge port into the array and holds the device busy for a parameterised number of cycles. The array reports a verify failure on the acknowledge, and the block records it.

Each word address falls in one of seven erase blocks of unequal size:
- a boot block of 1/32 of the space;
- two parameter blocks of 1/64 each;
- one main block of 3/16;
- three main blocks of 1/4 each.

A parameter puts the boot block at the top of the map. The bottom placement mirrors the whole order. Program or erase aimed at the boot block only proceeds while the boot-unlock input is high.

Holding the active-low reset/power-down input low does three things: it resets the sequencer, clears the status register and discards all writes. After release, commands are ignored for a wake-up delay, and reads return zero for a longer read delay.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: Block index (0 = boot, 1 = parameter next to boot, 2 = other parameter, 3 = 3/16 main, 4..6 = quarter mains, 4 nearest the boot end). With BOOT_TOP=1 and N words, the word address ranges map as follows, and BOOT_TOP=0 maps address a as BOOT_TOP=1 maps N-1-a:

  | Word address range | Block |
  |---|---|
  | [0,N/4) | 6 |
  | [N/4,N/2) | 5 |
  | [N/2,3N/4) | 4 |
  | [3N/4,15N/16) | 3 |
  | [15N/16,61N/64) | 2 |
  | [61N/64,31N/32) | 1 |
  | [31N/32,N) | 0 |

- R2: Writing 0x40 (low data byte) and then a write at address A raises `arr_req` with `arr_erase`=0 at word A. In word mode the data is the full word with `arr_be`=2'b11. In byte mode the word is host_addr[ADDR_W:1], `arr_be` is 2'b10 for host_addr[0]=1 and 2'b01 for host_addr[0]=0, and the data byte is copied to both lanes.
- R3: Writing 0x20 and then 0xD0 at address A raises `arr_req` with `arr_erase`=1 and `arr_blk` equal to the block of A. Only that block is erased.
- R4: After 0x20, a second write whose low byte is not 0xD0 starts nothing. It sets status bits 5 and 4 and returns to array-read mode.
- R5: With `boot_unlock` low, program or erase aimed at block 0 raises no request and sets status bit 3. Other blocks are unaffected by `boot_unlock`.
- R6: While an operation runs, the following hold:
  - status bit 7 reads 0 and every read returns the status;
  - every write is ignored;
  - `arr_req` and its fields hold until `arr_ack`;
  - the busy period lasts at least PROG_CYC or ERASE_CYC cycles and does not end before the acknowledge.
- R7: `arr_fail` at the acknowledge sets status bit 4 for a program or bit 5 for an erase. A clean run leaves the status at 0x80.
- R8: Error bits 5, 4 and 3 stay set until a write of 0x50. A write of 0x70 selects status reads and 0xFF selects array reads. Status reads return {8'h00, status}. After any operation the block is in status-read mode.
- R9: While `rst_n` is low, the following hold:
  - `arr_req` is 0 and `host_rdata` is 0;
  - the status error bits are cleared;
  - an operation in progress is abandoned.
- R10: Counting rising clock edges after `rst_n` is released, the following hold:
  - a write sampled while fewer than WAKE_CYC edges have passed is ignored;
  - a read sampled while fewer than READ_CYC edges have passed returns 0.
- R11: A read (`host_rd`) loads `host_rdata` at the next clock edge. In byte mode an array read returns the lane picked by host_addr[0] (1 = upper byte) in bits 7:0, with bits 15:8 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset / power-down |
| boot_unlock | input | 1 | High permits program/erase of the boot block |
| byte_mode | input | 1 | 1 = 8-bit bus addressing, 0 = 16-bit |
| host_addr | input | ADDR_W+1 | Host address (byte address in byte mode, word address in bits ADDR_W-1:0 otherwise) |
| host_wdata | input | 16 | Host write data; commands in bits 7:0 |
| host_we | input | 1 | Host write strobe, one cycle per write |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 16 | Registered read data |
| arr_rd | output | 1 | Array read strobe for the current host address |
| arr_req | output | 1 | Array operation request, held until acknowledged |
| arr_erase | output | 1 | 1 = erase block, 0 = program word |
| arr_addr | output | ADDR_W | Array word address |
| arr_blk | output | 3 | Target erase block index |
| arr_wdata | output | 16 | Program data |
| arr_be | output | 2 | Program byte enables |
| arr_rdata | input | 16 | Array read data for `arr_addr` |
| arr_ack | input | 1 | Array operation acknowledge |
| arr_fail | input | 1 | Verify failure, valid with `arr_ack` |

## Verification
The hardest conditions to reach are those that depend on exact cycle positions: the edge of the wake-up window, and a reset that lands inside a running erase. For the wake-up case, the stimulus counts edges from reset release and places a status command one edge before writes open. It then waits past the read delay and shows that the command left no trace, because the next read still returns array data. For the reset case, an erase is started after an erase-sequence error has been raised, and reset is pulled while the array has not yet acknowledged. The status read after wake-up must show ready with no error bits. A full address sweep of erases checks the block index for both boot placements at once, using a second instance built with the mirrored map.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        MODE_ARRAY  = 3'd0,
        MODE_STATUS = 3'd1,
        MODE_PSETUP = 3'd2,
        MODE_ESETUP = 3'd3,
        MODE_BUSY   = 3'd4
    } mode_e;

    localparam logic [7:0] CMD_PROG_SETUP  = 8'h40;
    localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
    localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
    localparam logic [7:0] CMD_STATUS_RD   = 8'h70;
    localparam logic [7:0] CMD_STATUS_CLR  = 8'h50;
    localparam logic [7:0] CMD_ARRAY_RD    = 8'hFF;

    localparam logic [2:0] BLK_BOOT = 3'd0;

endpackage

// File: rtl/flash_blk_map.sv
module flash_blk_map #(
    parameter int ADDR_W   = 18,
    parameter bit BOOT_TOP = 1'b1
) (
    input  logic [ADDR_W-1:0] waddr,
    output logic [2:0]        blk
);
    logic [ADDR_W-1:0] norm;
    logic [2:0]        eighth;

    generate
        if (BOOT_TOP) begin : g_top
            assign norm = waddr;
        end else begin : g_bottom
            assign norm = ~waddr;
        end
    endgenerate

    assign eighth = norm[ADDR_W-3:ADDR_W-5];

    always_comb begin
        case (norm[ADDR_W-1:ADDR_W-2])
            2'b00:   blk = 3'd6;
            2'b01:   blk = 3'd5;
            2'b10:   blk = 3'd4;
            default: begin
                if (eighth < 3'd6)       blk = 3'd3;
                else if (eighth == 3'd6) blk = norm[ADDR_W-6] ? 3'd1 : 3'd2;
                else                     blk = 3'd0;
            end
        endcase
    end
endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)             cnt_d = load_val;
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/flash_wake_gate.sv
module flash_wake_gate #(
    parameter int WAKE_CYC = 8,
    parameter int READ_CYC = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic wr_ok,
    output logic rd_ok
);
    localparam int WW = $clog2(READ_CYC + 1);
    localparam logic [WW-1:0] WAKE_V = WW'(WAKE_CYC);
    localparam logic [WW-1:0] READ_V = WW'(READ_CYC);

    logic [WW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q < READ_V) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign wr_ok = (cnt_q >= WAKE_V);
    assign rd_ok = (cnt_q >= READ_V);
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter bit BOOT_TOP  = 1'b1,
    parameter int PROG_CYC  = 16,
    parameter int ERASE_CYC = 64,
    parameter int WAKE_CYC  = 8,
    parameter int READ_CYC  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_unlock,
    input  logic              byte_mode,
    input  logic [ADDR_W:0]   host_addr,
    input  logic [15:0]       host_wdata,
    input  logic              host_we,
    input  logic              host_rd,
    output logic [15:0]       host_rdata,
    output logic              arr_rd,
    output logic              arr_req,
    output logic              arr_erase,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [2:0]        arr_blk,
    output logic [15:0]       arr_wdata,
    output logic [1:0]        arr_be,
    input  logic [15:0]       arr_rdata,
    input  logic              arr_ack,
    input  logic              arr_fail
);
    localparam int LONGEST = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int TW      = $clog2(LONGEST + 1);
    localparam logic [TW-1:0] PROG_V  = TW'(PROG_CYC);
    localparam logic [TW-1:0] ERASE_V = TW'(ERASE_CYC);

    typedef struct packed {
        mode_e             mode;
        logic              is_erase;
        logic              req;
        logic              ack_seen;
        logic              fail;
        logic              e_erase;
        logic              e_prog;
        logic              e_lock;
        logic [ADDR_W-1:0] op_addr;
        logic [2:0]        op_blk;
        logic [15:0]       op_data;
        logic [1:0]        op_be;
        logic [15:0]       rdata;
    } state_t;

    state_t st_d, st_q;

    logic [ADDR_W-1:0] waddr;
    logic [2:0]        blk_now;
    logic              wr_ok, rd_ok, tmr_zero, start;
    logic              busy, wr_go, locked, fail_now;
    logic [7:0]        cmd, status;

    assign waddr = byte_mode ? host_addr[ADDR_W:1] : host_addr[ADDR_W-1:0];

    flash_blk_map #(.ADDR_W(ADDR_W), .BOOT_TOP(BOOT_TOP)) u_map (
        .waddr (waddr),
        .blk   (blk_now)
    );

    flash_wake_gate #(.WAKE_CYC(WAKE_CYC), .READ_CYC(READ_CYC)) u_wake (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_ok (wr_ok),
        .rd_ok (rd_ok)
    );

    flash_op_timer #(.CW(TW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .load_val (st_d.is_erase ? ERASE_V : PROG_V),
        .zero     (tmr_zero)
    );

    assign busy     = (st_q.mode == MODE_BUSY);
    assign wr_go    = host_we && wr_ok && !busy;
    assign cmd      = host_wdata[7:0];
    assign locked   = (blk_now == BLK_BOOT) && !boot_unlock;
    assign status   = {!busy, 1'b0, st_q.e_erase, st_q.e_prog, st_q.e_lock, 3'b000};
    assign fail_now = st_q.ack_seen ? st_q.fail : arr_fail;

    always_comb begin
        st_d  = st_q;
        start = 1'b0;
        if (busy) begin
            if (arr_ack) begin
                st_d.req      = 1'b0;
                st_d.ack_seen = 1'b1;
                st_d.fail     = arr_fail;
            end
            if ((st_q.ack_seen || arr_ack) && tmr_zero) begin
                st_d.mode = MODE_STATUS;
                if (st_q.is_erase) st_d.e_erase = st_q.e_erase | fail_now;
                else               st_d.e_prog  = st_q.e_prog  | fail_now;
            end
        end else if (wr_go) begin
            case (st_q.mode)
                MODE_PSETUP, MODE_ESETUP: begin
                    if (st_q.mode == MODE_ESETUP && cmd != CMD_ERASE_GO) begin
                        st_d.e_erase = 1'b1;
                        st_d.e_prog  = 1'b1;
                        st_d.mode    = MODE_ARRAY;
                    end else if (locked) begin
                        st_d.e_lock = 1'b1;
                        st_d.mode   = MODE_STATUS;
                    end else begin
                        start         = 1'b1;
                        st_d.mode     = MODE_BUSY;
                        st_d.is_erase = (st_q.mode == MODE_ESETUP);
                        st_d.req      = 1'b1;
                        st_d.ack_seen = 1'b0;
                        st_d.fail     = 1'b0;
                        st_d.op_addr  = waddr;
                        st_d.op_blk   = blk_now;
                        if (byte_mode) begin
                            st_d.op_data = {cmd, cmd};
                            st_d.op_be   = host_addr[0] ? 2'b10 : 2'b01;
                        end else begin
                            st_d.op_data = host_wdata;
                            st_d.op_be   = 2'b11;
                        end
                    end
                end
                default: begin
                    case (cmd)
                        CMD_PROG_SETUP:  st_d.mode = MODE_PSETUP;
                        CMD_ERASE_SETUP: st_d.mode = MODE_ESETUP;
                        CMD_STATUS_RD:   st_d.mode = MODE_STATUS;
                        CMD_ARRAY_RD:    st_d.mode = MODE_ARRAY;
                        CMD_STATUS_CLR: begin
                            st_d.e_erase = 1'b0;
                            st_d.e_prog  = 1'b0;
                            st_d.e_lock  = 1'b0;
                        end
                        default: ;
                    endcase
                end
            endcase
        end

        if (host_rd) begin
            if (!rd_ok)                        st_d.rdata = 16'h0000;
            else if (st_q.mode != MODE_ARRAY)  st_d.rdata = {8'h00, status};
            else if (byte_mode)                st_d.rdata = {8'h00, host_addr[0] ? arr_rdata[15:8] : arr_rdata[7:0]};
            else                               st_d.rdata = arr_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= MODE_ARRAY;
        end else begin
            st_q <= st_d;
        end
    end

    assign host_rdata = st_q.rdata;
    assign arr_rd     = host_rd && rd_ok && (st_q.mode == MODE_ARRAY);
    assign arr_req    = st_q.req;
    assign arr_erase  = st_q.is_erase;
    assign arr_addr   = busy ? st_q.op_addr : waddr;
    assign arr_blk    = st_q.op_blk;
    assign arr_wdata  = st_q.op_data;
    assign arr_be     = st_q.op_be;
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk #(
    parameter int ADDR_W   = 18,
    parameter int WAKE_CYC = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              boot_unlock,
    input logic              arr_req,
    input logic              arr_ack,
    input logic              arr_erase,
    input logic [ADDR_W-1:0] arr_addr,
    input logic [2:0]        arr_blk
);
    localparam int CW = $clog2(WAKE_CYC + 3);
    localparam logic [CW-1:0] LIM = CW'(WAKE_CYC + 2);

    logic [CW-1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            since_rst <= '0;
        else if (since_rst != LIM) since_rst <= since_rst + 1'b1;
    end

    // R9
    no_req_in_reset_chk: assert property (@(posedge clk) !rst_n |-> !arr_req);

    // R10
    no_req_before_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < LIM) |-> !arr_req);

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_req && !arr_ack) |=> arr_req);

    // R6
    op_fields_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_req && !arr_ack) |=> ($stable(arr_addr) && $stable(arr_blk) && $stable(arr_erase)));

    // R6
    req_drop_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_ack |=> !arr_req);

    // R5
    boot_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(arr_req) && arr_blk == 3'd0) |-> $past(boot_unlock));
endmodule

bind flash_cmd_ctrl flash_cmd_chk #(.ADDR_W(ADDR_W), .WAKE_CYC(WAKE_CYC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .boot_unlock (boot_unlock),
    .arr_req     (arr_req),
    .arr_ack     (arr_ack),
    .arr_erase   (arr_erase),
    .arr_addr    (arr_addr),
    .arr_blk     (arr_blk)
);

// File: tb/flash_cmd_ctrl_bench.sv
module flash_cmd_ctrl_bench;
    localparam int AW = 8;
    localparam int PC = 3;
    localparam int EC = 5;
    localparam int WC = 4;
    localparam int RC = 10;
    localparam int N  = 1 << AW;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n = 1'b0, boot_unlock = 1'b0, byte_mode = 1'b0;
    logic [AW:0]   host_addr = '0;
    logic [15:0]   host_wdata = '0;
    logic          host_we = 1'b0, host_rd = 1'b0;
    logic [15:0]   host_rdata, arr_wdata, arr_rdata;
    logic          arr_rd, arr_req, arr_erase, arr_ack = 1'b0, arr_fail = 1'b0;
    logic [AW-1:0] arr_addr;
    logic [2:0]    arr_blk;
    logic [1:0]    arr_be;

    logic [15:0]   b_rdata, b_wdata;
    logic          b_rd, b_req, b_erase;
    logic [AW-1:0] b_addr;
    logic [2:0]    b_blk;
    logic [1:0]    b_be;

    flash_cmd_ctrl #(.ADDR_W(AW), .BOOT_TOP(1'b1), .PROG_CYC(PC), .ERASE_CYC(EC),
                     .WAKE_CYC(WC), .READ_CYC(RC)) u_flash_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .boot_unlock(boot_unlock), .byte_mode(byte_mode),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_we(host_we), .host_rd(host_rd),
        .host_rdata(host_rdata), .arr_rd(arr_rd), .arr_req(arr_req), .arr_erase(arr_erase),
        .arr_addr(arr_addr), .arr_blk(arr_blk), .arr_wdata(arr_wdata), .arr_be(arr_be),
        .arr_rdata(arr_rdata), .arr_ack(arr_ack), .arr_fail(arr_fail));

    flash_cmd_ctrl #(.ADDR_W(AW), .BOOT_TOP(1'b0), .PROG_CYC(PC), .ERASE_CYC(EC),
                     .WAKE_CYC(WC), .READ_CYC(RC)) u_bot (
        .clk(clk), .rst_n(rst_n), .boot_unlock(boot_unlock), .byte_mode(byte_mode),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_we(host_we), .host_rd(host_rd),
        .host_rdata(b_rdata), .arr_rd(b_rd), .arr_req(b_req), .arr_erase(b_erase),
        .arr_addr(b_addr), .arr_blk(b_blk), .arr_wdata(b_wdata), .arr_be(b_be),
        .arr_rdata(16'h0000), .arr_ack(b_req), .arr_fail(1'b0));

    int total = 0, bad = 0, cyc = 0, nreq = 0, ack_dly = 1, dcnt = 0;
    bit inject = 1'b0, req_prev = 1'b0;
    logic [15:0] mem [0:N-1];

    function automatic int exp_blk(input int a);
        if (a < N/4)            return 6;
        if (a < N/2)            return 5;
        if (a < 3*N/4)          return 4;
        if (a < 15*N/16)        return 3;
        if (a < 61*N/64)        return 2;
        if (a < 31*N/32)        return 1;
        return 0;
    endfunction

    assign arr_rdata = mem[arr_addr];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        req_prev <= arr_req;
        if (arr_req && !req_prev) nreq <= nreq + 1;
        arr_ack <= 1'b0;
        if (!arr_req) dcnt <= 0;
        else if (!arr_ack) begin
            if (dcnt >= ack_dly) begin
                arr_ack  <= 1'b1;
                arr_fail <= inject;
                dcnt     <= 0;
                if (arr_erase) begin
                    for (int i = 0; i < N; i++)
                        if (exp_blk(i) == int'(arr_blk)) mem[i] <= 16'hFFFF;
                end else begin
                    if (arr_be[0]) mem[arr_addr][7:0]  <= arr_wdata[7:0];
                    if (arr_be[1]) mem[arr_addr][15:8] <= arr_wdata[15:8];
                end
            end else dcnt <= dcnt + 1;
        end
    end

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        host_addr = (AW+1)'(a); host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [15:0] v);
        @(negedge clk);
        host_addr = (AW+1)'(a); host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        v = host_rdata;
    endtask

    task automatic wait_ready(output logic [15:0] s);
        s = 16'h0;
        for (int i = 0; i < 200 && !s[7]; i++) rd(0, s);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL R6 watchdog act=%0d exp=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] v, s;
        int t0, n0;
        for (int i = 0; i < N; i++) mem[i] = 16'hA000 + 16'(i);

        // R9: reset state
        repeat (3) @(negedge clk);
        check("R9", "req in reset", {31'd0, arr_req}, 0);
        check("R9", "rdata in reset", {16'd0, host_rdata}, 0);

        // R10: wake-up window
        @(negedge clk); rst_n = 1'b1;
        repeat (WC - 2) @(negedge clk);
        wr(0, 16'h0070);
        rd(5, v);
        check("R10", "early read", {16'd0, v}, 0);
        repeat (RC) @(negedge clk);
        rd(5, v);
        check("R10", "early write ignored", {16'd0, v}, 32'hA005);
        wr(0, 16'h0070);
        rd(5, v);
        check("R8", "status after 0x70", {16'd0, v}, 32'h0080);
        wr(0, 16'h00FF);

        // R11: byte reads
        byte_mode = 1'b1;
        rd(10, v);
        check("R11", "low lane", {16'd0, v}, 32'h0005);
        rd(11, v);
        check("R11", "high lane", {16'd0, v}, 32'h00A0);
        byte_mode = 1'b0;

        // R1 / R3: erase sweep over every address, both placements
        boot_unlock = 1'b1;
        for (int a = 0; a < N; a++) begin
            wr(a, 16'h0020);
            wr(a, 16'h00D0);
            check("R3", "erase req", {30'd0, arr_req, arr_erase}, 32'h3);
            check("R1", "top block", {29'd0, arr_blk}, exp_blk(a));
            check("R1", "bottom block", {29'd0, b_blk}, exp_blk(N - 1 - a));
            wait_ready(s);
            check("R7", "clean erase status", {16'd0, s}, 32'h0080);
        end

        // R2 / R3: program, then erase one block only
        wr(0, 16'h0040); wr(10, 16'h1234);
        check("R2", "word be", {30'd0, arr_be}, 32'h3);
        wait_ready(s);
        wr(0, 16'h0040); wr(70, 16'h5678); wait_ready(s);
        wr(0, 16'h0020); wr(100, 16'h00D0); wait_ready(s);
        wr(0, 16'h00FF);
        rd(10, v);
        check("R3", "other block kept", {16'd0, v}, 32'h1234);
        rd(70, v);
        check("R3", "target block erased", {16'd0, v}, 32'hFFFF);

        // R2: byte-mode program into upper lane
        byte_mode = 1'b1;
        wr(0, 16'h0040); wr(2*20 + 1, 16'h005A);
        check("R2", "byte be", {30'd0, arr_be}, 32'h2);
        check("R2", "byte addr", {24'd0, arr_addr}, 20);
        wait_ready(s);
        byte_mode = 1'b0;
        wr(0, 16'h00FF);
        rd(20, v);
        check("R2", "byte program result", {16'd0, v}, 32'h5AFF);

        // R6: busy, writes ignored, ack later than timer
        ack_dly = 8;
        wr(0, 16'h0040); wr(12, 16'h0F0F);
        t0 = cyc;
        rd(12, v);
        check("R6", "busy status", {16'd0, v}, 32'h0000);
        wr(0, 16'h00FF);
        wait_ready(s);
        check("R6", "busy until ack", (cyc - t0 >= 8) ? 1 : 0, 1);
        rd(12, v);
        check("R6", "write during busy ignored", {16'd0, v}, 32'h0080);
        ack_dly = 0;
        wr(0, 16'h0020); wr(12, 16'h00D0);
        t0 = cyc;
        wait_ready(s);
        check("R6", "erase busy length", (cyc - t0 >= EC) ? 1 : 0, 1);

        // R7 / R8: failure reporting and clearing
        ack_dly = 1; inject = 1'b1;
        wr(0, 16'h0040); wr(30, 16'h0001); wait_ready(s);
        check("R7", "program fail", {16'd0, s}, 32'h0090);
        wr(0, 16'h0050); rd(0, v);
        check("R8", "clear status", {16'd0, v}, 32'h0080);
        wr(0, 16'h0020); wr(30, 16'h00D0); wait_ready(s);
        check("R7", "erase fail", {16'd0, s}, 32'h00A0);
        inject = 1'b0;
        wr(0, 16'h0050);

        // R5: boot lock
        boot_unlock = 1'b0;
        n0 = nreq;
        wr(0, 16'h0040); wr(N - 6, 16'h1111);
        rd(0, v);
        check("R5", "locked program status", {16'd0, v}, 32'h0088);
        wr(0, 16'h0050);
        wr(0, 16'h0020); wr(N - 1, 16'h00D0);
        rd(0, v);
        check("R5", "locked erase status", {16'd0, v}, 32'h0088);
        check("R5", "no request", nreq - n0, 0);
        wr(0, 16'h0050);
        wr(0, 16'h0020); wr(61*N/64, 16'h00D0);
        check("R5", "param erase allowed", {31'd0, arr_req}, 1);
        wait_ready(s);
        wr(0, 16'h00FF);
        rd(N - 6, v);
        check("R5", "boot word unchanged", {16'd0, v}, 32'hFFFF);

        // R4 / R8: bad erase confirm, sticky bits
        wr(0, 16'h0020); wr(7, 16'h00FF);
        rd(7, v);
        check("R4", "back to array", {16'd0, v}, 32'hFFFF);
        wr(0, 16'h0070); rd(0, v);
        check("R4", "both error bits", {16'd0, v}, 32'h00B0);
        wr(0, 16'h00FF); wr(0, 16'h0070); rd(0, v);
        check("R8", "bits sticky", {16'd0, v}, 32'h00B0);

        // R9: reset during erase clears status
        ack_dly = 20;
        wr(0, 16'h0020); wr(40, 16'h00D0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R9", "req dropped", {31'd0, arr_req}, 0);
        check("R9", "rdata cleared", {16'd0, host_rdata}, 0);
        rst_n = 1'b1; ack_dly = 1;
        repeat (RC + 2) @(negedge clk);
        wr(0, 16'h0070); rd(0, v);
        check("R9", "status cleared", {16'd0, v}, 32'h0080);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule